// File: doc/BRIEF.md
# Double-Banked Audio Slot Buffer

This block sits between a parallel audio word source and a serial time-division multiplexer. One dual-port memory is split into two equal halves. While the writer fills one half with the current buffer period's words, the reader drains the other half, one bit per multiplexer audio time slot. A frame-start pulse from the multiplexer's timing swaps the two halves. The words written during one period are therefore read out in order during the next, and the serial stream continues across the swap without a gap.

Because the reader only ever touches the half that finished filling in the previous period, it never fetches a location that is still being written. If the writer did not fill its half completely before a swap, an underrun flag warns that the period being read holds stale data. Each half holds `HALF_WORDS` words of `WORD_W` bits. The defaults are 60 words of 8 bits, which is 480 bits and matches a 48 kbps stream framed every 10 ms. The memory is written so that block RAM can be inferred.

The interface assumes that `slot_en` pulses are at least two clock cycles apart, and at least two cycles after a `frame_start` pulse.

Top module: `pp_audio_buffer`

## Requirements
- R1: After synchronous reset, `wr_bank` is 0 (low half takes writes), `underrun` is 1 and `ser_bit` is 0.
- R2: Each `frame_start` pulse inverts `wr_bank` at the next clock edge. Without such a pulse, `wr_bank` holds its value.
- R3: Words accepted in one period are stored in the write half at consecutive word positions, starting from word 0 after each swap. During the following period they are read back from that half in the same order.
- R4: Each `slot_en` strobe updates `ser_bit` at the next clock edge with one bit of the current word, most significant bit first. Between strobes, `ser_bit` holds its value.
- R5: The read position moves to the next word after the `WORD_W`-th bit of a word. A swap resets the read position to bit `WORD_W-1` of word 0 of the new read half, even if it arrives in the middle of a word.
- R6: Once `HALF_WORDS` words have been accepted in a period, further writes in that period are discarded. The half being read is never touched.
- R7: A write presented in the same cycle as `frame_start` is discarded and does not count toward filling either half. A `slot_en` in that cycle is also ignored.
- R8: At each swap, `underrun` becomes 1 if the half just handed to the reader received fewer than `HALF_WORDS` words, and 0 otherwise. Between swaps it holds its value.
- R9: Strobes beyond the last bit of word `HALF_WORDS-1` wrap the read position to word 0 of the same half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at each buffer period boundary; swaps the halves |
| wr_en | input | 1 | Write strobe for one audio word |
| wr_data | input | WORD_W | Audio word to store |
| slot_en | input | 1 | Audio time-slot strobe; requests one serial bit |
| ser_bit | output | 1 | Registered serial audio bit |
| wr_bank | output | 1 | Half currently taking writes (0 low, 1 high) |
| underrun | output | 1 | Set when the half being read was not completely filled |

## Verification
The bound checker watches four things on every cycle:
- that `wr_bank` toggles exactly on a swap and is otherwise steady;
- that `ser_bit` and `underrun` hold between their update events;
- that the write count never exceeds a half;
- that the bit position restarts on a swap.

Only the bench's scenarios can show the rest, because those properties concern data contents:
- that words written in one period come back MSB first in the next;
- that overflow writes and writes in the swap cycle leave the read half untouched;
- that a swap in the middle of a word restarts on word 0;
- that reading past the end wraps to the start of the same half.

// File: rtl/pp_audio_pkg.sv
package pp_audio_pkg;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  // Width able to hold values 0..n inclusive, never below one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Width able to index n items, never below one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pp_bank_ctrl.sv
module pp_bank_ctrl
  import pp_audio_pkg::*;
#(
  parameter int unsigned HALF_WORDS = 60,
  parameter int unsigned PW         = cnt_width(HALF_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          wr_en,
  output half_sel_e     bank,
  output logic [PW-1:0] wr_cnt,
  output logic          wr_go,
  output logic          underrun
);

  localparam logic [PW-1:0] FULL = PW'(HALF_WORDS);

  logic half_full;

  assign half_full = (wr_cnt == FULL);
  // A write is taken only outside a swap cycle and while the half has room.
  assign wr_go     = wr_en && !frame_start && !half_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank     <= HALF_LO;
      wr_cnt   <= '0;
      underrun <= 1'b1;
    end else if (frame_start) begin
      bank     <= (bank == HALF_LO) ? HALF_HI : HALF_LO;
      wr_cnt   <= '0;
      underrun <= !half_full;
    end else if (wr_go) begin
      wr_cnt   <= wr_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pp_dpram.sv
module pp_dpram #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned DEPTH  = 120,
  parameter int unsigned AW     = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pp_serializer.sv
module pp_serializer
  import pp_audio_pkg::*;
#(
  parameter int unsigned WORD_W     = 8,
  parameter int unsigned HALF_WORDS = 60,
  parameter int unsigned PW         = cnt_width(HALF_WORDS),
  parameter int unsigned BW         = idx_width(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              slot_en,
  input  logic [WORD_W-1:0] rd_word,
  output logic [PW-1:0]     rd_ptr,
  output logic [BW-1:0]     rd_bit,
  output logic              ser_bit
);

  localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W - 1);
  localparam logic [PW-1:0] LAST_WORD = PW'(HALF_WORDS - 1);

  logic [BW-1:0] msb_idx;

  // Bit 0 of the count selects the most significant bit of the word.
  assign msb_idx = LAST_BIT - rd_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      rd_bit  <= '0;
      ser_bit <= 1'b0;
    end else if (frame_start) begin
      rd_ptr <= '0;
      rd_bit <= '0;
    end else if (slot_en) begin
      ser_bit <= rd_word[msb_idx];
      if (rd_bit == LAST_BIT) begin
        rd_bit <= '0;
        rd_ptr <= (rd_ptr == LAST_WORD) ? '0 : rd_ptr + 1'b1;
      end else begin
        rd_bit <= rd_bit + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pp_audio_buffer.sv
module pp_audio_buffer
  import pp_audio_pkg::*;
#(
  parameter int unsigned WORD_W     = 8,
  parameter int unsigned HALF_WORDS = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              slot_en,
  output logic              ser_bit,
  output logic              wr_bank,
  output logic              underrun
);

  localparam int unsigned DEPTH = 2 * HALF_WORDS;
  localparam int unsigned AW    = idx_width(DEPTH);
  localparam int unsigned PW    = cnt_width(HALF_WORDS);
  localparam int unsigned BW    = idx_width(WORD_W);
  localparam logic [AW-1:0] HI_BASE = AW'(HALF_WORDS);

  half_sel_e         bank;
  logic [PW-1:0]     wr_cnt;
  logic              wr_go;
  logic [PW-1:0]     rd_ptr;
  logic [BW-1:0]     rd_bit;
  logic [AW-1:0]     waddr;
  logic [AW-1:0]     raddr;
  logic [WORD_W-1:0] rd_word;

  pp_bank_ctrl #(
    .HALF_WORDS (HALF_WORDS),
    .PW         (PW)
  ) u_bank (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .wr_en       (wr_en),
    .bank        (bank),
    .wr_cnt      (wr_cnt),
    .wr_go       (wr_go),
    .underrun    (underrun)
  );

  // Writer targets the selected half; reader always uses the other one.
  assign waddr = (bank == HALF_HI) ? HI_BASE + AW'(wr_cnt) : AW'(wr_cnt);
  assign raddr = (bank == HALF_HI) ? AW'(rd_ptr) : HI_BASE + AW'(rd_ptr);

  pp_dpram #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH),
    .AW     (AW)
  ) u_ram (
    .clk   (clk),
    .we    (wr_go),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rd_word)
  );

  pp_serializer #(
    .WORD_W     (WORD_W),
    .HALF_WORDS (HALF_WORDS),
    .PW         (PW),
    .BW         (BW)
  ) u_ser (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .slot_en     (slot_en),
    .rd_word     (rd_word),
    .rd_ptr      (rd_ptr),
    .rd_bit      (rd_bit),
    .ser_bit     (ser_bit)
  );

  assign wr_bank = (bank == HALF_HI);

endmodule

// File: rtl/pp_audio_buffer_chk.sv
module pp_audio_buffer_chk #(
  parameter int unsigned HALF_WORDS = 60,
  parameter int unsigned PW         = 6,
  parameter int unsigned BW         = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic          slot_en,
  input logic          ser_bit,
  input logic          wr_bank,
  input logic          underrun,
  input logic [PW-1:0] wr_cnt,
  input logic [BW-1:0] rd_bit
);

  // R2
  bank_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (wr_bank != $past(wr_bank)));

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(wr_bank));

  // R4
  ser_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !slot_en |=> $stable(ser_bit));

  // R4 (interface assumption: strobes are spaced)
  slot_gap_chk: assert property (@(posedge clk) disable iff (rst)
    slot_en |=> !slot_en);

  // R5
  bit_restart_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (rd_bit == '0));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cnt <= PW'(HALF_WORDS));

  // R8
  under_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(underrun));

endmodule

bind pp_audio_buffer pp_audio_buffer_chk #(
  .HALF_WORDS (HALF_WORDS),
  .PW         (PW),
  .BW         (BW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .slot_en     (slot_en),
  .ser_bit     (ser_bit),
  .wr_bank     (wr_bank),
  .underrun    (underrun),
  .wr_cnt      (wr_cnt),
  .rd_bit      (rd_bit)
);

// File: tb/pp_audio_buffer_test.sv
`timescale 1ns/1ps
module pp_audio_buffer_test;

  localparam int W = 8;
  localparam int H = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         frame_start = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         slot_en = 1'b0;
  logic         ser_bit;
  logic         wr_bank;
  logic         underrun;

  always #2.5 clk = ~clk;

  pp_audio_buffer #(.WORD_W(W), .HALF_WORDS(H)) uut (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .slot_en     (slot_en),
    .ser_bit     (ser_bit),
    .wr_bank     (wr_bank),
    .underrun    (underrun)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Reference model built from the requirements.
  logic [W-1:0] mdl [2][H];
  int m_bank = 0, m_wp = 0, m_rp = 0, m_bit = 0;
  logic m_under = 1'b1;
  logic last_bit = 1'b0;

  // Scoreboard queue of expected serial bits and their requirement tags.
  logic  exp_q[$];
  string tag_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: samples the serial output after each strobe edge.
  always @(posedge clk) begin
    if (!rst && slot_en && !frame_start) begin
      #1;
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R4 actual=%0b expected=<none>", ser_bit);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {31'b0, ser_bit}, {31'b0, e});
      end
    end
  end

  // Driver tasks: each one starts and ends at a falling edge.
  task automatic put_word(input logic [W-1:0] w);
    wr_en = 1'b1; wr_data = w;
    if (m_wp < H) begin
      mdl[m_bank][m_wp] = w;
      m_wp++;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic swap(input logic with_wr, input logic [W-1:0] w);
    frame_start = 1'b1; wr_en = with_wr; wr_data = w;
    @(negedge clk);
    frame_start = 1'b0; wr_en = 1'b0;
    m_under = (m_wp != H);
    m_bank  = 1 - m_bank;
    m_wp = 0; m_rp = 0; m_bit = 0;
    check("R2", {31'b0, wr_bank}, m_bank);
    check("R8", {31'b0, underrun}, {31'b0, m_under});
    @(negedge clk);
  endtask

  task automatic strobe(input string req);
    logic [W-1:0] wd;
    slot_en = 1'b1;
    wd = mdl[1 - m_bank][m_rp];
    last_bit = wd[W-1-m_bit];
    exp_q.push_back(last_bit);
    tag_q.push_back(req);
    m_bit++;
    if (m_bit == W) begin
      m_bit = 0;
      m_rp  = (m_rp + 1) % H;
    end
    @(negedge clk);
    slot_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    check("R1", {31'b0, wr_bank}, 0);
    check("R1", {31'b0, underrun}, 1);
    check("R1", {31'b0, ser_bit}, 0);

    // Period 0: fill low half completely.
    put_word(8'hA5); put_word(8'h3C); put_word(8'hF0); put_word(8'h96);
    swap(1'b0, '0);                      // R2, R8: full half, no underrun

    // Period 1: partial fill of high half, read the whole low half.
    put_word(8'h81); put_word(8'h7E);
    for (int i = 0; i < H * W; i++) strobe("R3");
    // R4: output holds between strobes
    repeat (3) @(negedge clk);
    check("R4", {31'b0, ser_bit}, {31'b0, last_bit});
    // R9: wrap to word 0 of the same half, leave mid-word
    for (int i = 0; i < 3; i++) strobe("R9");
    swap(1'b0, '0);                      // R8: only two words, underrun

    // Period 2: overfill low half, then read high half from its start.
    for (int i = 0; i < H + 2; i++) put_word(W'(8'h10 + i));
    // R5: mid-word swap restarts at MSB of word 0; R6: read half untouched
    for (int i = 0; i < 2 * W; i++) strobe("R6");
    swap(1'b0, '0);                      // R8: full, no underrun

    // Period 3: three words, then a write in the swap cycle.
    put_word(8'hC3); put_word(8'h5A); put_word(8'hE1);
    for (int i = 0; i < W; i++) strobe("R5");
    swap(1'b1, 8'hFF);                   // R7: discarded write keeps underrun set
    check("R7", {31'b0, underrun}, 1);

    // Period 4: read back the three words.
    for (int i = 0; i < 3 * W; i++) strobe("R3");

    repeat (3) @(negedge clk);
    check("R4", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule